// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block watches the command lines of a four-bank synchronous DRAM and checks the rules that govern closing and reopening rows. On each rising clock edge where the command strobe is valid, it decodes activate, read, write and precharge. It keeps a flag per bank that shows whether the bank holds an open row. It also keeps three small countdowns per bank: one for the precharge recovery time, one for the write-recovery window and one for the read window.

When a command breaks a rule, the block emits a one-cycle violation pulse with a 3-bit code and the index of the offending bank. The block is meant to sit beside a memory controller or a command bus model as a protocol monitor. All timing values are elaboration parameters counted in clock cycles. Refresh, mode-register writes and the data path are outside its scope.

Top module: `sdram_pre_guard`

## Requirements
- R1: A command is decoded only when `cmd_vld` is high at a rising edge, from the active-low pins {cs_n, ras_n, cas_n, we_n}. Activate is 0011, read is 0101, write is 0100 and precharge is 0010. Every other pattern, or `cmd_vld` low, is a no-operation and changes no state and no output.
- R2: With `a10` low, a precharge closes only the bank addressed by `ba`, and other banks keep their state. With `a10` high, a precharge closes every bank, and `ba` is ignored.
- R3: A read or write to a closed bank produces violation code 1 naming that bank. It does not arm any timing window.
- R4: A precharge starts a recovery window for that bank:
  - An activate to the bank sampled fewer than `T_RP` edges after the precharge produces code 2.
  - An activate exactly `T_RP` edges after the precharge is legal.
  - The bank opens in either case.
- R5: Let w be the edge of a write to an open bank. Its last data beat is at w+`BURST_LEN`-1. A precharge to that bank before w+`BURST_LEN`-1+`T_DPL` produces code 3. A precharge at that edge or later is legal.
- R6: Let r be the edge of a read to an open bank. Its last data beat is at r+`CAS_LAT`+`BURST_LEN`-1. A precharge to that bank earlier than `CAS_LAT`-1 edges before that beat produces code 4. With the defaults, any precharge before r+4 produces code 4.
- R7: An activate to a bank that is already open produces code 5, and the bank stays open.
- R8: A precharge to a closed bank is legal and restarts that bank's `T_RP` window.
- R9: The violation outputs update on the clock edge after the command edge and last one cycle:
  - `viol_pulse` is high exactly when `viol_code` is non-zero, and code 0 means no violation.
  - When a precharge-all breaks rules in several banks, the lowest bank index is reported.
  - Within a bank, code 3 takes priority over code 4.
- R10: Synchronous active-low reset closes all banks, satisfies every timing window and clears the violation outputs.
- R11: `bank_open[i]` reflects the command state after each edge. `bank_act_ok[i]` is high only for a closed bank whose `T_RP` window has expired. After a precharge, it stays low for `T_RP`-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command lines carry a valid command this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | All-banks select for precharge |
| ba | input | 2 | Bank address |
| bank_open | output | 4 | Per-bank open-row flag |
| bank_act_ok | output | 4 | Per-bank closed and ready for activate |
| viol_pulse | output | 1 | One-cycle violation indicator |
| viol_code | output | 3 | Violation kind (0 none, 1 closed access, 2 tRP, 3 tDPL, 4 early read precharge, 5 double activate) |
| viol_bank | output | 2 | Bank index of the reported violation |

## Verification
The bound checker compares each decoded command against the next cycle's outputs on every cycle. It checks four things: invalid strobes stay silent, a precharge-all empties every bank, and accesses to closed banks or double activates give the right code and bank. It also checks that an activate to a ready bank never violates and that the pulse and a non-zero code always agree.

Multi-cycle window boundaries can only be shown by the bench's cycle-exact sequences. These cover write recovery and the read-precharge window, including the first legal edge, the recovery restart on a closed bank, and lowest-index selection on precharge-all.

// File: rtl/sdram_pre_pkg.sv
// Package: shared command and violation encodings for the precharge tracker.
// Assumes one command per clock; codes are consumed by the tracker's outputs.
package sdram_pre_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        VIO_NONE    = 3'd0,
        VIO_CLOSED  = 3'd1,
        VIO_TRP     = 3'd2,
        VIO_TDPL    = 3'd3,
        VIO_RDEARLY = 3'd4,
        VIO_DBLACT  = 3'd5
    } vio_e;

    // Largest of three cycle counts, used to size the per-bank counters.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: turns the active-low command pins into a command kind.
// Assumes pins are stable at the sampling edge; invalid strobe gives NOP.
module sdram_cmd_decode
    import sdram_pre_pkg::*;
(
    input  logic cmd_vld,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Pin pattern lookup; unlisted patterns and deselect are no-operations.
    always_comb begin
        cmd = CMD_NOP;
        if (cmd_vld) begin
            unique case ({cs_n, ras_n, cas_n, we_n})
                4'b0011: cmd = CMD_ACT;
                4'b0101: cmd = CMD_RD;
                4'b0100: cmd = CMD_WR;
                4'b0010: cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Module: state and timing windows for a single bank.
// Assumes hit is already qualified by bank address or precharge-all.
// Counters hold "edges still to wait"; zero means the rule is satisfied.
module sdram_bank_track
    import sdram_pre_pkg::*;
#(
    parameter int unsigned T_RP    = 3,
    parameter int unsigned WR_HOLD = 5,
    parameter int unsigned RD_HOLD = 4,
    parameter int unsigned CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             hit,
    output logic             is_open,
    output logic             act_ready,
    output logic [2:0]       bank_vio
);

    localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_HOLD - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_HOLD - 1);

    logic             open_q;
    logic [CNT_W-1:0] rp_cnt;
    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] rd_cnt;
    vio_e             vio;

    // Saturating decrement toward zero.
    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - CNT_W'(1);
    endfunction

    // Judge the current command against this bank's state.
    always_comb begin
        vio = VIO_NONE;
        if (hit) begin
            unique case (cmd)
                CMD_ACT: begin
                    if (open_q)              vio = VIO_DBLACT;
                    else if (rp_cnt != '0)   vio = VIO_TRP;
                end
                CMD_RD, CMD_WR: begin
                    if (!open_q)             vio = VIO_CLOSED;
                end
                CMD_PRE: begin
                    if (wr_cnt != '0)        vio = VIO_TDPL;
                    else if (rd_cnt != '0)   vio = VIO_RDEARLY;
                end
                default:                     vio = VIO_NONE;
            endcase
        end
    end

    // Advance the open flag and the three windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            rp_cnt <= '0;
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            rp_cnt <= step(rp_cnt);
            wr_cnt <= step(wr_cnt);
            rd_cnt <= step(rd_cnt);
            if (hit) begin
                unique case (cmd)
                    CMD_ACT: open_q <= 1'b1;
                    CMD_RD:  if (open_q) rd_cnt <= RD_LOAD;
                    CMD_WR:  if (open_q) wr_cnt <= WR_LOAD;
                    CMD_PRE: begin
                        open_q <= 1'b0;
                        rp_cnt <= RP_LOAD;
                        wr_cnt <= '0;
                        rd_cnt <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign is_open   = open_q;
    assign act_ready = !open_q && (rp_cnt == '0);
    assign bank_vio  = vio;

endmodule

// File: rtl/sdram_vio_pick.sv
// Module: selects the lowest-indexed bank that reports a violation.
// Assumes code zero means "no violation" for a bank.
module sdram_vio_pick #(
    parameter int unsigned NB = 4,
    parameter int unsigned IW = 2
) (
    input  logic [NB-1:0][2:0] codes,
    output logic               found,
    output logic [2:0]         code,
    output logic [IW-1:0]      idx
);

    // Scan from the top down so the lowest index wins.
    always_comb begin
        found = 1'b0;
        code  = '0;
        idx   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (codes[i] != 3'd0) begin
                found = 1'b1;
                code  = codes[i];
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/sdram_pre_guard.sv
// Module: top of the precharge timing tracker.
// Decodes each valid command, routes it to per-bank trackers and registers
// one violation report per cycle. Assumes all timings are at least one cycle.
module sdram_pre_guard
    import sdram_pre_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned CAS_LAT   = 3,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_DPL     = 2,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 a10,
    input  logic [BANK_W-1:0]    ba,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_act_ok,
    output logic                 viol_pulse,
    output logic [2:0]           viol_code,
    output logic [BANK_W-1:0]    viol_bank
);

    // Write: last beat at w+BL-1, then T_DPL more edges.
    localparam int unsigned WR_HOLD = BURST_LEN - 1 + T_DPL;
    // Read: last beat at r+CL+BL-1, precharge allowed CL-1 before it.
    localparam int unsigned RD_HOLD = (CAS_LAT + BURST_LEN - 1) - (CAS_LAT - 1);
    localparam int unsigned CNT_W   = $clog2(max3(T_RP, WR_HOLD, RD_HOLD) + 1);

    cmd_e                      cmd;
    logic [NUM_BANKS-1:0][2:0] bank_codes;
    logic                      pick_found;
    logic [2:0]                pick_code;
    logic [BANK_W-1:0]         pick_idx;
    logic                      pulse_q;
    logic [2:0]                code_q;
    logic [BANK_W-1:0]         bank_q;

    sdram_cmd_decode u_dec (
        .cmd_vld (cmd_vld),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cmd     (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        // Bank is targeted by its address or by precharge-all.
        assign hit = (ba == BANK_W'(b)) || (cmd == CMD_PRE && a10);

        sdram_bank_track #(
            .T_RP    (T_RP),
            .WR_HOLD (WR_HOLD),
            .RD_HOLD (RD_HOLD),
            .CNT_W   (CNT_W)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .hit       (hit),
            .is_open   (bank_open[b]),
            .act_ready (bank_act_ok[b]),
            .bank_vio  (bank_codes[b])
        );
    end

    sdram_vio_pick #(
        .NB (NUM_BANKS),
        .IW (BANK_W)
    ) u_pick (
        .codes (bank_codes),
        .found (pick_found),
        .code  (pick_code),
        .idx   (pick_idx)
    );

    // Register one violation report per command edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            code_q  <= '0;
            bank_q  <= '0;
        end else begin
            pulse_q <= pick_found;
            code_q  <= pick_code;
            bank_q  <= pick_idx;
        end
    end

    assign viol_pulse = pulse_q;
    assign viol_code  = code_q;
    assign viol_bank  = bank_q;

endmodule

// File: rtl/sdram_pre_guard_chk.sv
// Module: protocol checker bound to the tracker top; observes ports only.
module sdram_pre_guard_chk #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_vld,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 a10,
    input logic [BANK_W-1:0]    ba,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_act_ok,
    input logic                 viol_pulse,
    input logic [2:0]           viol_code,
    input logic [BANK_W-1:0]    viol_bank
);

    logic is_act, is_acc, is_pre;
    assign is_act = cmd_vld && ({cs_n, ras_n, cas_n, we_n} == 4'b0011);
    assign is_acc = cmd_vld && ({cs_n, ras_n, cas_n} == 3'b010);
    assign is_pre = cmd_vld && ({cs_n, ras_n, cas_n, we_n} == 4'b0010);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> !viol_pulse);

    assert_pre_all_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10) |=> (bank_open == '0));

    assert_closed_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_acc && !bank_open[ba]) |=>
            (viol_pulse && viol_code == 3'd1 && viol_bank == $past(ba)));

    assert_ready_activate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_act_ok[ba]) |=> !viol_pulse);

    assert_double_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open[ba]) |=>
            (viol_pulse && viol_code == 3'd5 && bank_open[$past(ba)]));

    assert_pre_blocks_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (T_RP > 1 && is_pre && !a10) |=> !bank_act_ok[$past(ba)]);

    assert_pulse_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse == (viol_code != 3'd0));

endmodule

bind sdram_pre_guard sdram_pre_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RP      (T_RP),
    .BANK_W    (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld     (cmd_vld),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .a10         (a10),
    .ba          (ba),
    .bank_open   (bank_open),
    .bank_act_ok (bank_act_ok),
    .viol_pulse  (viol_pulse),
    .viol_code   (viol_code),
    .viol_bank   (viol_bank)
);

// File: tb/sdram_pre_guard_tb.sv
module sdram_pre_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int T_RP       = 3;
    localparam int N_ROWS     = 35;

    // Command kinds used by the stimulus table.
    localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                           K_PRE = 3'd4, K_IDLE = 3'd5, K_DES = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] bank_open, bank_act_ok;
    logic       viol_pulse;
    logic [2:0] viol_code;
    logic [1:0] viol_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_pre_guard u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_vld (cmd_vld), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .a10 (a10), .ba (ba),
        .bank_open (bank_open), .bank_act_ok (bank_act_ok),
        .viol_pulse (viol_pulse), .viol_code (viol_code), .viol_bank (viol_bank)
    );

    // Row: {req, kind, a10, ba, exp_code, exp_bank, exp_open}
    function automatic logic [18:0] vr(input logic [3:0] req, input logic [2:0] kind,
        input logic a, input logic [1:0] b, input logic [2:0] c,
        input logic [1:0] vb, input logic [3:0] op);
        return {req, kind, a, b, c, vb, op};
    endfunction

    localparam logic [18:0] TBL [N_ROWS] = '{
        vr(1, K_ACT, 0, 0, 0, 0, 4'b0001),  // 0  R1 activate b0
        vr(1, K_WR,  0, 0, 0, 0, 4'b0001),  // 1  R1 write b0 (w=1)
        vr(3, K_RD,  0, 1, 1, 1, 4'b0001),  // 2  R3 read closed b1
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0001),  // 3
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0001),  // 4
        vr(5, K_PRE, 0, 0, 3, 0, 4'b0000),  // 5  R5 precharge at w+4
        vr(4, K_ACT, 0, 0, 2, 0, 4'b0001),  // 6  R4 activate 1 after pre
        vr(1, K_RD,  0, 0, 0, 0, 4'b0001),  // 7  read b0 (r=7)
        vr(7, K_ACT, 0, 0, 5, 0, 4'b0001),  // 8  R7 double activate
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0001),  // 9
        vr(6, K_PRE, 0, 0, 4, 0, 4'b0000),  // 10 R6 precharge at r+3
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0000),  // 11
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0000),  // 12
        vr(4, K_ACT, 0, 0, 0, 0, 4'b0001),  // 13 R4 activate exactly T_RP after
        vr(1, K_WR,  0, 0, 0, 0, 4'b0001),  // 14 write b0 (w=14)
        vr(1, K_ACT, 0, 2, 0, 0, 4'b0101),  // 15
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0101),  // 16
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0101),  // 17
        vr(1, K_NOP, 0, 0, 0, 0, 4'b0101),  // 18
        vr(5, K_PRE, 0, 0, 0, 0, 4'b0100),  // 19 R5 boundary legal, R2 single bank
        vr(1, K_RD,  0, 2, 0, 0, 4'b0100),  // 20 read b2 (r=20)
        vr(1, K_IDLE,0, 0, 0, 0, 4'b0100),  // 21 R1 strobe low ignored
        vr(1, K_DES, 0, 1, 0, 0, 4'b0100),  // 22 R1 deselect ignored
        vr(2, K_PRE, 1, 3, 4, 2, 4'b0000),  // 23 R2 all banks, ba ignored
        vr(8, K_ACT, 0, 3, 2, 3, 4'b1000),  // 24 R8 closed bank got window
        vr(1, K_NOP, 0, 0, 0, 0, 4'b1000),  // 25
        vr(4, K_ACT, 0, 1, 0, 0, 4'b1010),  // 26
        vr(8, K_PRE, 0, 0, 0, 0, 4'b1010),  // 27 R8 precharge closed legal
        vr(8, K_ACT, 0, 0, 2, 0, 4'b1011),  // 28 R8 window restarted
        vr(1, K_WR,  0, 1, 0, 0, 4'b1011),  // 29
        vr(1, K_RD,  0, 3, 0, 0, 4'b1011),  // 30
        vr(9, K_PRE, 1, 0, 3, 1, 4'b0000),  // 31 R9 lowest bank wins
        vr(8, K_PRE, 0, 2, 0, 0, 4'b0000),  // 32
        vr(3, K_WR,  0, 2, 1, 2, 4'b0000),  // 33 R3 write closed
        vr(9, K_NOP, 0, 0, 0, 0, 4'b0000)   // 34 R9 pulse ends
    };

    task automatic drive(input logic [2:0] kind, input logic a, input logic [1:0] b);
        cmd_vld = 1'b1; a10 = a; ba = b;
        case (kind)
            K_ACT:  {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            K_RD:   {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            K_WR:   {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            K_PRE:  {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            K_IDLE: begin cmd_vld = 1'b0; {cs_n, ras_n, cas_n, we_n} = 4'b0011; end
            K_DES:  {cs_n, ras_n, cas_n, we_n} = 4'b1011;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        drive(K_NOP, 0, 0);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset", {6'd0, bank_open, bank_act_ok, viol_pulse, viol_code},
              {6'd0, 4'b0000, 4'b1111, 1'b0, 3'd0});
        rst_n = 1'b1;

        for (int k = 0; k < N_ROWS; k++) begin
            logic [18:0] row;
            logic [3:0]  req;
            row = TBL[k];
            req = row[18:15];
            drive(row[14:12], row[11], row[10:9]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", req, k),
                  {7'd0, viol_pulse, viol_code,
                   (viol_pulse ? viol_bank : 2'd0), bank_open},
                  {7'd0, (row[8:6] != 3'd0), row[8:6], row[5:4], row[3:0]});
        end

        // R11 ready flag timing after a precharge
        drive(K_ACT, 0, 1);
        @(negedge clk);
        check("R11 open not ready", {14'd0, bank_open[1], bank_act_ok[1]}, {14'd0, 2'b10});
        drive(K_PRE, 0, 1);
        for (int j = 0; j < T_RP; j++) begin
            @(negedge clk);
            check("R11 ready timing", {15'd0, bank_act_ok[1]}, {15'd0, (j == T_RP - 1)});
            drive(K_NOP, 0, 0);
        end

        // R10 mid-run reset clears open rows and windows
        drive(K_ACT, 0, 3);
        @(negedge clk);
        drive(K_PRE, 0, 2);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset", {6'd0, bank_open, bank_act_ok, viol_pulse, viol_code},
              {6'd0, 4'b0000, 4'b1111, 1'b0, 3'd0});
        rst_n = 1'b1;
        drive(K_RD, 0, 3);
        @(negedge clk);
        check("R3 after reset", {11'd0, viol_pulse, viol_code, viol_bank},
              {11'd0, 1'b1, 3'd1, 2'd3});

        finish_run();
    end

endmodule